// File: doc/BRIEF.md
# Multichannel DMA Control and Interrupt Registers

This block is the register file that software uses to configure and monitor a sixteen-channel DMA controller. It also merges the channel events into a single interrupt line. A small memory-mapped port carries an address, a write strobe, write data and registered read data. Through that port software sets:

- the per-channel enables;
- a core run bit;
- four operating-mode flags;
- a two-bit cap on the access width;
- two levels of interrupt enable;
- a per-channel completion mask.

The decoded settings leave the block as plain level outputs that the transfer engine consumes.

The engine reports back through three per-channel input vectors: running, a one-cycle completion pulse and a one-cycle error pulse. Running flags are mirrored into the status word. Completions are held there until software re-arms the channel.

Qualifying completion and error events raise a one-cycle interrupt pulse. Writing 1 to the soft-reset bit of the control word sets every register in the block back to zero in the same write.

Top module: `mcdma_regs_top`

## Requirements
- R1: After the synchronous reset, the control, status and mask words read 0, `irq` is 0 and all configuration outputs are 0.
- R2: The control word at offset 0x0 has the following fields:
  - bits 31:16 are the channel enables (bit 16+n is channel n, driven on `ch_enable[n]`);
  - bit 7 is no-starve, bit 6 is extended descriptors, bit 5 is timer enable and bit 4 is simplified mode;
  - bit 3 is the error interrupt enable, bit 2 is the global interrupt enable and bit 0 is run.
  Each field reads back what was written, and the mode and run bits drive their outputs in the cycle after the write.
- R3: Control bits 13:12 hold the width cap, which is decoded on `width_limit`:
  - code 0 gives 3'b000 (no cap);
  - code 1 gives 3'b001 (32-bit);
  - code 2 gives 3'b010 (64-bit);
  - code 3 gives 3'b100 (128-bit).
  At most one bit of `width_limit` is ever set.
- R4: A control write with bit 1 set ignores its other bits. It clears the control, mask and status words and suppresses `irq`, all at that clock edge. Bit 1 always reads 0.
- R5: While the global interrupt enable (control bit 2) is 0, `irq` stays 0 whatever the events.
- R6: An error pulse raises `irq` only when control bits 2 and 3 are both 1.
- R7: Status bits 31:16 show the `ch_running` vector one cycle late. Status bit n is set by a `ch_done[n]` pulse and stays set.
- R8: Status bit n is cleared by a control write that takes channel enable n from 0 to 1. It is not cleared by rewriting an enable that is already 1, nor by clearing one. If a set and a clear land in the same cycle, the set wins.
- R9: The mask word at offset 0x8 bits 15:0 gates completion interrupts per channel: 0 blocks them, 1 passes them when the global enable is 1.
- R10: Reserved bits read as 0: control bits 15:14, 11:8 and 1, and mask bits 31:16. Any offset other than 0x0, 0x4 and 0x8 reads 0. Read data appears one cycle after the address.
- R11: `irq` is a one-cycle pulse, registered, in the cycle after a cycle holding a qualifying event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ch_running | input | 16 | Per-channel running flags from the engine |
| ch_done | input | 16 | Per-channel completion pulses |
| ch_error | input | 16 | Per-channel error pulses |
| ch_enable | output | 16 | Per-channel enables |
| core_run | output | 1 | Core run enable |
| width_limit | output | 3 | Decoded access width cap (one-hot or zero) |
| nostarve_mode | output | 1 | Switch queue after every descriptor |
| ext_desc_mode | output | 1 | Extended conditional descriptors enabled |
| timer_en | output | 1 | Timeout timer for triggered descriptors |
| simple_mode | output | 1 | Simplified operation |
| irq | output | 1 | Interrupt pulse |

## Verification
The checker watches four properties on every cycle:
- the global-enable gate and the error two-level gate on `irq`;
- the fact that with every completion masked and no error, `irq` stays quiet;
- the one-hot shape of the width cap.

It also checks the effect of soft reset and of enable writes in the following cycle, and that a completion pulse sets its sticky status bit.

Only the bench's sweeps can show the full field layout and reserved-bit readback across all 32 control bits. They also cover the exact per-channel mask pairing and the re-arm rule that clears status only on a 0-to-1 enable edge. Finally, they check the address map for every unused offset.

// File: rtl/mcdma_pkg.sv
package mcdma_pkg;

  localparam int unsigned DATA_W = 32;

  // Byte offsets of the register words
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_MASK = 4'h8;

  // Control word bit positions
  localparam int unsigned CB_RUN      = 0;
  localparam int unsigned CB_SRST     = 1;
  localparam int unsigned CB_GIE      = 2;
  localparam int unsigned CB_EIE      = 3;
  localparam int unsigned CB_SIMPLE   = 4;
  localparam int unsigned CB_TIMER    = 5;
  localparam int unsigned CB_EXT      = 6;
  localparam int unsigned CB_NOSTARVE = 7;
  localparam int unsigned CB_CAP_LO   = 12;
  localparam int unsigned CB_EN_LO    = 16;
  localparam int unsigned SB_RUN_LO   = 16;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_32   = 2'd1,
    CAP_64   = 2'd2,
    CAP_128  = 2'd3
  } cap_e;

  typedef struct packed {
    logic nostarve;
    logic ext;
    logic timer;
    logic simple;
    logic eie;
    logic gie;
    logic run;
    cap_e cap;
  } mode_t;

  function automatic logic [2:0] cap_decode(input cap_e c);
    logic [2:0] r;
    unique case (c)
      CAP_32:  r = 3'b001;
      CAP_64:  r = 3'b010;
      CAP_128: r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcdma_ctrl_reg.sv
module mcdma_ctrl_reg
  import mcdma_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    en_q,
  output mode_t             mode_q,
  output logic [NCH-1:0]    mask_q,
  output logic [NCH-1:0]    en_rise,
  output logic              srst
);

  // Soft reset acts in the same edge as the write that requests it
  assign srst = wr_ctrl & wdata[CB_SRST];

  // Only a 0-to-1 edge written by software re-arms a channel
  assign en_rise = (wr_ctrl && !srst) ? (wdata[CB_EN_LO +: NCH] & ~en_q) : '0;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      en_q   <= '0;
      mode_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q            <= wdata[CB_EN_LO +: NCH];
        mode_q.nostarve <= wdata[CB_NOSTARVE];
        mode_q.ext      <= wdata[CB_EXT];
        mode_q.timer    <= wdata[CB_TIMER];
        mode_q.simple   <= wdata[CB_SIMPLE];
        mode_q.eie      <= wdata[CB_EIE];
        mode_q.gie      <= wdata[CB_GIE];
        mode_q.run      <= wdata[CB_RUN];
        mode_q.cap      <= cap_e'(wdata[CB_CAP_LO +: 2]);
      end
      if (wr_mask) begin
        mask_q <= wdata[NCH-1:0];
      end
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[15:14], wdata[11:8]};

endmodule

// File: rtl/mcdma_chan_status.sv
module mcdma_chan_status #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_all,
  input  logic [NCH-1:0] running_i,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] rearm_i,
  output logic [NCH-1:0] run_q,
  output logic [NCH-1:0] done_q
);

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      run_q  <= '0;
      done_q <= '0;
    end else begin
      run_q  <= running_i;
      // a completion arriving with a re-arm keeps the bit set
      done_q <= (done_q & ~rearm_i) | done_i;
    end
  end

endmodule

// File: rtl/mcdma_irq_merge.sv
module mcdma_irq_merge #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_all,
  input  logic           gie,
  input  logic           eie,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] err_i,
  output logic           irq_q
);

  logic done_hit;
  logic err_hit;

  assign done_hit = |(done_i & mask);
  assign err_hit  = eie & (|err_i);

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= gie & (done_hit | err_hit);
    end
  end

endmodule

// File: rtl/mcdma_regs_top.sv
module mcdma_regs_top
  import mcdma_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    ch_running,
  input  logic [NCH-1:0]    ch_done,
  input  logic [NCH-1:0]    ch_error,
  output logic [NCH-1:0]    ch_enable,
  output logic              core_run,
  output logic [2:0]        width_limit,
  output logic              nostarve_mode,
  output logic              ext_desc_mode,
  output logic              timer_en,
  output logic              simple_mode,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);

  logic           wr_ctrl;
  logic           wr_mask;
  logic           srst;
  mode_t          mode_q;
  logic [NCH-1:0] en_rise;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] run_q;
  logic [NCH-1:0] done_q;
  logic           gie;
  logic           eie;

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_mask = reg_we && (reg_addr == A_MASK);

  mcdma_ctrl_reg #(.NCH(NCH)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_mask (wr_mask),
    .wdata   (reg_wdata),
    .en_q    (ch_enable),
    .mode_q  (mode_q),
    .mask_q  (mask_q),
    .en_rise (en_rise),
    .srst    (srst)
  );

  mcdma_chan_status #(.NCH(NCH)) stat_i (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (srst),
    .running_i (ch_running),
    .done_i    (ch_done),
    .rearm_i   (en_rise),
    .run_q     (run_q),
    .done_q    (done_q)
  );

  assign gie = mode_q.gie;
  assign eie = mode_q.eie;

  mcdma_irq_merge #(.NCH(NCH)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .clr_all (srst),
    .gie     (gie),
    .eie     (eie),
    .mask    (mask_q),
    .done_i  (ch_done),
    .err_i   (ch_error),
    .irq_q   (irq)
  );

  assign core_run      = mode_q.run;
  assign nostarve_mode = mode_q.nostarve;
  assign ext_desc_mode = mode_q.ext;
  assign timer_en      = mode_q.timer;
  assign simple_mode   = mode_q.simple;
  assign width_limit   = cap_decode(mode_q.cap);

  // Read words assembled from stored state
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] mask_word;

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[CB_EN_LO +: NCH]  = ch_enable;
    ctrl_word[CB_CAP_LO +: 2]   = mode_q.cap;
    ctrl_word[CB_NOSTARVE]      = mode_q.nostarve;
    ctrl_word[CB_EXT]           = mode_q.ext;
    ctrl_word[CB_TIMER]         = mode_q.timer;
    ctrl_word[CB_SIMPLE]        = mode_q.simple;
    ctrl_word[CB_EIE]           = mode_q.eie;
    ctrl_word[CB_GIE]           = mode_q.gie;
    ctrl_word[CB_RUN]           = mode_q.run;
    stat_word                   = '0;
    stat_word[SB_RUN_LO +: NCH] = run_q;
    stat_word[NCH-1:0]          = done_q;
    mask_word                   = '0;
    mask_word[NCH-1:0]          = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        A_CTRL:  reg_rdata <= ctrl_word;
        A_STAT:  reg_rdata <= stat_word;
        A_MASK:  reg_rdata <= mask_word;
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mcdma_regs_chk.sv
module mcdma_regs_chk
  import mcdma_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NCH-1:0]    ch_done,
  input logic [NCH-1:0]    ch_error,
  input logic [NCH-1:0]    ch_enable,
  input logic [2:0]        width_limit,
  input logic              irq,
  input logic              gie,
  input logic              eie,
  input logic [NCH-1:0]    mask_q,
  input logic [NCH-1:0]    done_q
);

  logic ctrl_wr;
  logic srst_wr;
  assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(OFF_CTRL));
  assign srst_wr = ctrl_wr && reg_wdata[CB_SRST];

  p_enable_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !srst_wr) |=> (ch_enable == $past(reg_wdata[CB_EN_LO +: NCH])));

  p_cap_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(width_limit));

  p_soft_reset_r4: assert property (@(posedge clk) disable iff (rst)
    srst_wr |=> (ch_enable == '0 && !irq && done_q == '0 && mask_q == '0));

  p_gie_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);

  p_err_gate_r6: assert property (@(posedge clk) disable iff (rst)
    ((ch_error != '0) && !(gie && eie) && ((ch_done & mask_q) == '0)) |=> !irq);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ((ch_done != '0) && !srst_wr) |=> ((done_q & $past(ch_done)) == $past(ch_done)));

  p_mask_block_r9: assert property (@(posedge clk) disable iff (rst)
    (((ch_done & mask_q) == '0) && (ch_error == '0)) |=> !irq);

endmodule

bind mcdma_regs_top mcdma_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .reg_addr    (reg_addr),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .ch_done     (ch_done),
  .ch_error    (ch_error),
  .ch_enable   (ch_enable),
  .width_limit (width_limit),
  .irq         (irq),
  .gie         (gie),
  .eie         (eie),
  .mask_q      (mask_q),
  .done_q      (done_q)
);

// File: tb/mcdma_regs_top_tb_top.sv
`timescale 1ns/1ps
module mcdma_regs_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ch_running = '0;
  logic [15:0] ch_done = '0;
  logic [15:0] ch_error = '0;
  logic [15:0] ch_enable;
  logic        core_run;
  logic [2:0]  width_limit;
  logic        nostarve_mode;
  logic        ext_desc_mode;
  logic        timer_en;
  logic        simple_mode;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [31:0] CTRL_RW = 32'hFFFF_30FD;

  always #2.5 clk = ~clk;

  mcdma_regs_top dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_running(ch_running),
    .ch_done(ch_done), .ch_error(ch_error), .ch_enable(ch_enable),
    .core_run(core_run), .width_limit(width_limit),
    .nostarve_mode(nostarve_mode), .ext_desc_mode(ext_desc_mode),
    .timer_en(timer_en), .simple_mode(simple_mode), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Pulse events for one cycle; report irq in the next cycle and the one after
  task automatic pulse(input logic [15:0] dn, input logic [15:0] er,
                       output logic i1, output logic i2);
    @(negedge clk);
    ch_done = dn; ch_error = er;
    @(negedge clk);
    i1 = irq; ch_done = '0; ch_error = '0;
    @(negedge clk);
    i2 = irq;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic i1, i2;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 enables", {16'd0, ch_enable}, 32'd0);
    chk("R1 outputs", {25'd0, width_limit, core_run, nostarve_mode,
        ext_desc_mode, timer_en, simple_mode}, 32'd0);
    rd(4'h0, d); chk("R1 ctrl", d, 32'd0);
    rd(4'h4, d); chk("R1 stat", d, 32'd0);
    rd(4'h8, d); chk("R1 mask", d, 32'd0);

    // R2 all writable bits, outputs
    wr(4'h0, 32'hFFFF_FFFD);
    rd(4'h0, d); chk("R2 ctrl all", d, CTRL_RW);
    chk("R2 enables", {16'd0, ch_enable}, 32'h0000_FFFF);
    chk("R2 modes", {27'd0, core_run, nostarve_mode, ext_desc_mode, timer_en, simple_mode},
        32'h1F);
    // R2/R10 walking-bit sweep over the control word
    for (int b = 0; b < 32; b++) begin
      if (b != 1) begin
        wr(4'h0, 32'd1 << b);
        rd(4'h0, d); chk($sformatf("R2 R10 ctrl bit %0d", b), d, (32'd1 << b) & CTRL_RW);
      end
    end
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R10 mask upper", d, 32'h0000_FFFF);

    // R3 width cap decode
    for (int c = 0; c < 4; c++) begin
      wr(4'h0, 32'(c) << 12);
      chk($sformatf("R3 cap %0d", c), {29'd0, width_limit},
          (c == 0) ? 32'd0 : (32'd1 << (c - 1)));
    end

    // R5 R6 R9 R11 interrupt gating sweep
    for (int g = 0; g < 4; g++) begin
      for (int m = 0; m < 2; m++) begin
        logic [15:0] mk;
        logic ge, ee;
        ge = g[0]; ee = g[1];
        mk = (m == 0) ? 16'hA5A5 : 16'h5A5A;
        wr(4'h0, {28'd0, ee, ge, 2'b00});
        wr(4'h8, {16'd0, mk});
        for (int ch = 0; ch < 16; ch++) begin
          pulse(16'd1 << ch, 16'd0, i1, i2);
          chk($sformatf("R5 R9 done ch%0d g%0d e%0d", ch, ge, ee), {31'd0, i1},
              {31'd0, ge & mk[ch]});
          chk("R11 pulse ends", {31'd0, i2}, 32'd0);
          pulse(16'd0, 16'd1 << ch, i1, i2);
          chk($sformatf("R6 err ch%0d g%0d e%0d", ch, ge, ee), {31'd0, i1},
              {31'd0, ge & ee});
        end
      end
    end

    // R4 soft reset clears everything
    wr(4'h0, 32'h0000_0004);
    wr(4'h8, 32'h0000_FFFF);
    pulse(16'h0F0F, 16'd0, i1, i2);
    wr(4'h0, 32'hFFFF_30FF);
    rd(4'h0, d); chk("R4 ctrl cleared", d, 32'd0);
    rd(4'h8, d); chk("R4 mask cleared", d, 32'd0);
    rd(4'h4, d); chk("R4 stat cleared", d, 32'd0);
    chk("R4 enables", {16'd0, ch_enable}, 32'd0);

    // R7 running mirror and sticky completion
    @(negedge clk); ch_running = 16'h1234;
    @(negedge clk);
    rd(4'h4, d); chk("R7 running", d, 32'h1234_0000);
    ch_running = '0;
    pulse(16'h00F0, 16'd0, i1, i2);
    repeat (4) @(negedge clk);
    rd(4'h4, d); chk("R7 done sticky", d, 32'h0000_00F0);

    // R8 re-arm on 0-to-1 enable edge only
    wr(4'h0, 32'h0030_0000);
    rd(4'h4, d); chk("R8 rise clears", d, 32'h0000_00C0);
    pulse(16'h0010, 16'd0, i1, i2);
    wr(4'h0, 32'h0030_0000);
    rd(4'h4, d); chk("R8 steady keeps", d, 32'h0000_00D0);
    wr(4'h0, 32'h0000_0000);
    rd(4'h4, d); chk("R8 fall keeps", d, 32'h0000_00D0);
    @(negedge clk);
    reg_addr = 4'h0; reg_we = 1'b1; reg_wdata = 32'h0040_0000; ch_done = 16'h0040;
    @(negedge clk);
    reg_we = 1'b0; ch_done = '0;
    rd(4'h4, d); chk("R8 set wins", d, 32'h0000_00D0);

    // R10 unused offsets read 0
    wr(4'h0, CTRL_RW);
    wr(4'h8, 32'h0000_FFFF);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        rd(4'(a), d); chk($sformatf("R10 offset %0h", a), d, 32'd0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule